// File: doc/BRIEF.md
# Shared Receive Silo for Eight Serial Lines

This block gathers received characters and modem-status change events from eight serial line receivers into one shared first-in first-out store. Every stored word describes itself. It carries the line it came from, the character, and flags for parity error, framing error (break), lost data, and modem-status change. A host drains the store through a single read address. It keeps reading while the returned word is negative, because the top bit is clear once the store is empty. A write to the same address does not reach the store. It loads a write-only silo parameter register, which is presented to neighbouring logic.

Each line has a one-deep holding register. When several lines present events in the same cycle, a fixed-priority arbiter moves the lowest-numbered pending line into the store first, one entry per cycle. Whenever an event has to be discarded, a pending-overrun mark is raised and placed on the next word written. This happens when the store is full, when a line's holding register is still occupied, or when a character and a modem change collide on one line. The receive-interrupt flag is high whenever the store holds at least one entry.

Occupancy is tracked by a three-state machine with states S_EMPTY, S_PART and S_FULL. Its transitions are:
- T_FIRST: S_EMPTY to S_PART on a write.
- T_FILL: S_PART to S_FULL on a write without a read at depth minus one.
- T_DRAIN: S_PART to S_EMPTY on a read without a write at one entry.
- T_UNFILL: S_FULL to S_PART on a read.

Top module: `rx_silo`

## Requirements
- R1: A read of a non-empty silo returns the word {bit15=1, bit14=overrun, bit13=framing error, bit12=parity error, bit11=modem change, bits10:8=line number, bits7:0=character}.
- R2: A read of an empty silo returns 16'h0000 (bit 15 clear) and changes no state.
- R3: A read returns the oldest entry and removes it at the same clock edge, so successive read cycles return entries in arrival order.
- R4: An event is captured into its line's holding register at the first edge. Events captured together enter the silo one per cycle, lowest line number first. A lone event enters the silo at the second edge after it is presented.
- R5: A modem change on a line makes an entry with bit 11 set and bits 13:12 and 7:0 zero. If a character arrives on the same line in the same cycle, the character is discarded as an overrun.
- R6: The silo holds 64 entries. An entry granted while the silo is full is discarded and the stored contents are unchanged.
- R7: Any discarded event sets a pending overrun. This happens when the silo is full, when a character and a modem change collide, or when a line's holding register is occupied and not granted that cycle. The pending overrun appears as bit 14 of the next entry written, and is then cleared.
- R8: rx_irq is high exactly while the silo holds at least one entry.
- R9: A write strobe loads wr_data into silo_param on the next edge and does not alter silo contents or rx_irq.
- R10: Reset empties the silo and the holding registers, clears the pending overrun and sets silo_param to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| line_vld | input | 8 | Per-line character-valid strobe |
| line_data | input | 64 | Per-line character, line i in bits 8i+7:8i |
| line_perr | input | 8 | Per-line parity error, qualified by line_vld |
| line_ferr | input | 8 | Per-line framing error, qualified by line_vld |
| line_mdm | input | 8 | Per-line modem-status change strobe |
| rd_en | input | 1 | Host read of the receive buffer address |
| wr_en | input | 1 | Host write of the same address |
| wr_data | input | 16 | Write data for the silo parameter register |
| rd_data | output | 16 | Receive buffer word |
| rx_irq | output | 1 | Receive-interrupt flag, silo not empty |
| silo_param | output | 16 | Silo parameter register value |

## Verification
A read pointer that slips, or an occupancy state that disagrees with the count, shows up on the very next read as a wrong or out-of-order word. It can also show up as rx_irq dropping while words remain. A fault in the arbiter or a holding register shows as the wrong order of lines within a few cycles of a simultaneous burst, or as a lost entry. A pending-overrun mark that is not set or not cleared only becomes visible on the next entry written after a discard. The bench therefore follows every forced discard with a fresh character and checks its bit 14.

// File: rtl/rxs_pkg.sv
package rxs_pkg;
    localparam int LINE_W = 3;
    localparam int CHAR_W = 8;

    typedef struct packed {
        logic              ovr;
        logic              ferr;
        logic              perr;
        logic              dsc;
        logic [LINE_W-1:0] line;
        logic [CHAR_W-1:0] chr;
    } rxs_entry_t;

    localparam int ENTRY_W = $bits(rxs_entry_t);

    typedef enum logic [1:0] {
        S_EMPTY = 2'd0,
        S_PART  = 2'd1,
        S_FULL  = 2'd2
    } silo_st_e;
endpackage

// File: rtl/rxs_hold.sv
module rxs_hold
    import rxs_pkg::*;
#(
    parameter int LINE_ID = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ev_chr,
    input  logic              ev_dsc,
    input  logic [CHAR_W-1:0] chr,
    input  logic              perr,
    input  logic              ferr,
    input  logic              grant,
    output logic              req,
    output rxs_entry_t        entry,
    output logic              lost
);
    logic       vld_q;
    rxs_entry_t ent_q;
    rxs_entry_t ent_d;
    logic       ev_any;
    logic       accept;

    assign ev_any = ev_chr | ev_dsc;
    assign accept = !vld_q || grant;

    always_comb begin
        ent_d      = '0;
        ent_d.line = LINE_W'(LINE_ID);
        if (ev_dsc) begin
            ent_d.dsc = 1'b1;
        end else begin
            ent_d.chr  = chr;
            ent_d.perr = perr;
            ent_d.ferr = ferr;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld_q <= 1'b0;
            ent_q <= '0;
        end else if (accept) begin
            vld_q <= ev_any;
            if (ev_any) ent_q <= ent_d;
        end
    end

    assign req   = vld_q;
    assign entry = ent_q;
    assign lost  = (ev_chr && ev_dsc) || (ev_any && !accept);

    // R4: a waiting entry stays put until the arbiter takes it
    p_hold_keeps_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (vld_q && !grant) |=> (vld_q && $stable(ent_q)));
endmodule

// File: rtl/rxs_arb.sv
module rxs_arb #(
    parameter int N  = 8,
    parameter int IW = 3
) (
    input  logic [N-1:0]  req,
    output logic [N-1:0]  grant,
    output logic [IW-1:0] idx,
    output logic          any
);
    always_comb begin
        grant = '0;
        idx   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) begin
                grant    = '0;
                grant[i] = 1'b1;
                idx      = IW'(i);
            end
        end
    end

    assign any = |req;
endmodule

// File: rtl/rxs_fifo.sv
module rxs_fifo
    import rxs_pkg::*;
#(
    parameter int DEPTH = 64,
    parameter int W     = 15
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] wdata,
    input  logic         pop,
    output logic [W-1:0] rdata,
    output logic         empty,
    output logic         full
);
    localparam int PTR_W = $clog2(DEPTH);
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic [W-1:0]     mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr, rd_ptr;
    logic [CNT_W-1:0] count_q;
    silo_st_e         state_q, state_d;
    logic             wr, rd;

    assign wr = push && !full;
    assign rd = pop && !empty;

    // next state: T_FIRST, T_FILL, T_DRAIN, T_UNFILL
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_EMPTY: if (wr) state_d = S_PART;
            S_PART: begin
                if (wr && !rd && count_q == CNT_W'(DEPTH - 1))
                    state_d = S_FULL;
                else if (rd && !wr && count_q == CNT_W'(1))
                    state_d = S_EMPTY;
            end
            S_FULL:  if (rd) state_d = S_PART;
            default: state_d = S_EMPTY;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= S_EMPTY;
        else        state_q <= state_d;
    end

    always_comb begin
        empty = (state_q == S_EMPTY);
        full  = (state_q == S_FULL);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr  <= '0;
            rd_ptr  <= '0;
            count_q <= '0;
        end else begin
            if (wr) wr_ptr <= wr_ptr + 1'b1;
            if (rd) rd_ptr <= rd_ptr + 1'b1;
            count_q <= count_q + CNT_W'(wr) - CNT_W'(rd);
        end
    end

    always_ff @(posedge clk) begin
        if (wr) mem[wr_ptr] <= wdata;
    end

    assign rdata = mem[rd_ptr];

    // R8: occupancy state agrees with the entry count
    p_state_count_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_EMPTY) == (count_q == '0));
    // R6: the count never passes the depth
    p_no_overflow_r6: assert property (@(posedge clk) disable iff (!rst_n)
        count_q <= CNT_W'(DEPTH));
    // R6: a push into a full silo without a read leaves it full
    p_full_drop_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (full && push && !pop) |=> (count_q == CNT_W'(DEPTH)));
endmodule

// File: rtl/rx_silo.sv
module rx_silo
    import rxs_pkg::*;
#(
    parameter int NLINES = 8,
    parameter int DEPTH  = 64
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [NLINES-1:0]        line_vld,
    input  logic [NLINES*CHAR_W-1:0] line_data,
    input  logic [NLINES-1:0]        line_perr,
    input  logic [NLINES-1:0]        line_ferr,
    input  logic [NLINES-1:0]        line_mdm,
    input  logic                     rd_en,
    input  logic                     wr_en,
    input  logic [15:0]              wr_data,
    output logic [15:0]              rd_data,
    output logic                     rx_irq,
    output logic [15:0]              silo_param
);
    localparam int IDX_W = (NLINES > 1) ? $clog2(NLINES) : 1;

    logic [NLINES-1:0] req, grant, lost;
    rxs_entry_t        hold_ent [NLINES];
    logic [IDX_W-1:0]  sel_idx;
    logic              push;
    rxs_entry_t        wr_ent;
    logic [ENTRY_W-1:0] head;
    logic              empty, full;
    logic              ovr_q, drop;
    logic [15:0]       param_q;

    for (genvar i = 0; i < NLINES; i++) begin : g_line
        rxs_hold #(.LINE_ID(i)) u_hold (
            .clk   (clk),
            .rst_n (rst_n),
            .ev_chr(line_vld[i]),
            .ev_dsc(line_mdm[i]),
            .chr   (line_data[i*CHAR_W +: CHAR_W]),
            .perr  (line_perr[i]),
            .ferr  (line_ferr[i]),
            .grant (grant[i]),
            .req   (req[i]),
            .entry (hold_ent[i]),
            .lost  (lost[i])
        );
    end

    rxs_arb #(.N(NLINES), .IW(IDX_W)) u_arb (
        .req  (req),
        .grant(grant),
        .idx  (sel_idx),
        .any  (push)
    );

    always_comb begin
        wr_ent     = hold_ent[sel_idx];
        wr_ent.ovr = ovr_q;
    end

    rxs_fifo #(.DEPTH(DEPTH), .W(ENTRY_W)) u_fifo (
        .clk  (clk),
        .rst_n(rst_n),
        .push (push),
        .wdata(wr_ent),
        .pop  (rd_en),
        .rdata(head),
        .empty(empty),
        .full (full)
    );

    assign drop = (push && full) || (|lost);

    always_ff @(posedge clk) begin
        if (!rst_n) ovr_q <= 1'b0;
        else        ovr_q <= drop || (ovr_q && !(push && !full));
    end

    always_ff @(posedge clk) begin
        if (!rst_n)      param_q <= '0;
        else if (wr_en)  param_q <= wr_data;
    end

    assign rd_data    = empty ? 16'h0000 : {1'b1, head};
    assign rx_irq     = !empty;
    assign silo_param = param_q;

    // R4: at most one line is granted per cycle
    p_grant_onehot_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant));
    // R7: a discard always leaves an overrun pending
    p_ovr_after_drop_r7: assert property (@(posedge clk) disable iff (!rst_n)
        drop |=> ovr_q);
    // R8: valid bit of the read word agrees with the interrupt flag
    p_valid_irq_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data[15] == rx_irq);
    // R9: the parameter register changes only on a write
    p_param_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(silo_param));
endmodule

// File: tb/rx_silo_bench.sv
module rx_silo_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  line_vld = '0, line_perr = '0, line_ferr = '0, line_mdm = '0;
    logic [63:0] line_data = '0;
    logic        rd_en = 1'b0, wr_en = 1'b0;
    logic [15:0] wr_data = '0;
    logic [15:0] rd_data, silo_param;
    logic        rx_irq;

    int checks = 0;
    int failures = 0;
    logic [15:0] exp_q [$];

    always #4 clk = ~clk;

    rx_silo u_rx_silo (
        .clk(clk), .rst_n(rst_n), .line_vld(line_vld), .line_data(line_data),
        .line_perr(line_perr), .line_ferr(line_ferr), .line_mdm(line_mdm),
        .rd_en(rd_en), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
        .rx_irq(rx_irq), .silo_param(silo_param)
    );

    function automatic logic [15:0] ent(input logic ovr, input logic ferr,
        input logic perr, input logic dsc, input logic [2:0] line, input logic [7:0] c);
        return {1'b1, ovr, ferr, perr, dsc, line, c};
    endfunction

    task automatic check(input bit ok, input string req, input logic [15:0] act,
                         input logic [15:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic send(input logic [7:0] vm, input logic [7:0] mm, input logic [7:0] pm,
                        input logic [7:0] fm, input logic [63:0] dat);
        @(negedge clk);
        line_vld = vm; line_mdm = mm; line_perr = pm; line_ferr = fm; line_data = dat;
        @(negedge clk);
        line_vld = '0; line_mdm = '0; line_perr = '0; line_ferr = '0; line_data = '0;
    endtask

    // monitor: reads while rx_irq, compares each word to the scoreboard
    task automatic drain(input string req);
        logic [15:0] e;
        repeat (4) @(negedge clk);
        while (rx_irq) begin
            rd_en = 1'b1;
            #1;
            if (exp_q.size() == 0) begin
                check(0, req, rd_data, 16'h0000);
            end else begin
                e = exp_q.pop_front();
                check(rd_data === e, req, rd_data, e);
            end
            @(negedge clk);
        end
        rd_en = 1'b0;
        check(exp_q.size() == 0, req, 16'(exp_q.size()), 16'h0000);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=running expected=done");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin : stim
        logic [63:0] d;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10 reset state
        check(rx_irq == 1'b0, "R10 irq", 16'(rx_irq), 16'h0);
        check(silo_param == 16'h0, "R10 param", silo_param, 16'h0);
        // R2 empty read
        rd_en = 1'b1; #1;
        check(rd_data == 16'h0000, "R2 empty read", rd_data, 16'h0000);
        @(negedge clk); rd_en = 1'b0;
        check(rx_irq == 1'b0, "R2 no state change", 16'(rx_irq), 16'h0);

        // R4/R8 latency of a lone character on line 3
        @(negedge clk);
        line_vld = 8'h08; line_data = 64'h41 << 24;
        @(negedge clk);
        line_vld = '0; line_data = '0;
        check(rx_irq == 1'b0, "R4 one edge", 16'(rx_irq), 16'h0);
        @(negedge clk);
        check(rx_irq == 1'b1, "R8 two edges", 16'(rx_irq), 16'h1);
        check(rd_data == ent(0,0,0,0,3'd3,8'h41), "R1 format", rd_data, ent(0,0,0,0,3'd3,8'h41));
        // R9 write with an entry present
        wr_en = 1'b1; wr_data = 16'h0001;
        @(negedge clk);
        wr_en = 1'b0; wr_data = '0;
        check(silo_param == 16'h0001, "R9 param", silo_param, 16'h0001);
        check(rx_irq == 1'b1, "R9 irq kept", 16'(rx_irq), 16'h1);
        exp_q.push_back(ent(0,0,0,0,3'd3,8'h41));
        drain("R3 R9 contents");
        check(rx_irq == 1'b0, "R8 empty after drain", 16'(rx_irq), 16'h0);

        // R4/R5/R1 simultaneous lines 0,2,5,7 plus modem change on 3
        d = '0;
        d[7:0] = 8'h10; d[23:16] = 8'h12; d[47:40] = 8'h15; d[63:56] = 8'h17;
        send(8'hA5, 8'h08, 8'h20, 8'h80, d);
        exp_q.push_back(ent(0,0,0,0,3'd0,8'h10));
        exp_q.push_back(ent(0,0,0,0,3'd2,8'h12));
        exp_q.push_back(ent(0,0,0,1,3'd3,8'h00));
        exp_q.push_back(ent(0,0,1,0,3'd5,8'h15));
        exp_q.push_back(ent(0,1,0,0,3'd7,8'h17));
        drain("R4 R5 priority order");

        // R5/R7 char and modem change collide on line 2
        d = '0; d[23:16] = 8'h99;
        send(8'h04, 8'h04, 8'h00, 8'h00, d);
        exp_q.push_back(ent(1,0,0,1,3'd2,8'h00));
        send(8'h02, 8'h00, 8'h00, 8'h00, 64'h33 << 8);
        exp_q.push_back(ent(0,0,0,0,3'd1,8'h33));
        drain("R5 collision");

        // R7 holding register busy: line 1 twice while line 0 drains first
        @(negedge clk);
        line_vld = 8'h03; line_data = '0; line_data[7:0] = 8'hA0; line_data[15:8] = 8'hA1;
        @(negedge clk);
        line_vld = 8'h02; line_data = '0; line_data[15:8] = 8'hB1;
        @(negedge clk);
        line_vld = '0; line_data = '0;
        exp_q.push_back(ent(0,0,0,0,3'd0,8'hA0));
        exp_q.push_back(ent(1,0,0,0,3'd1,8'hA1));
        drain("R7 hold busy");

        // R6/R7 fill to 64 and drop the 65th
        for (int k = 0; k < 65; k++) begin
            @(negedge clk);
            line_vld = 8'h01; line_data = 64'(k);
            if (k < 64) exp_q.push_back(ent(0,0,0,0,3'd0,8'(k)));
        end
        @(negedge clk);
        line_vld = '0; line_data = '0;
        repeat (3) @(negedge clk);
        check(rx_irq == 1'b1, "R6 full irq", 16'(rx_irq), 16'h1);
        check(rd_data == 16'h8000, "R3 head without read", rd_data, 16'h8000);
        drain("R6 depth 64");
        send(8'h01, 8'h00, 8'h00, 8'h00, 64'h5A);
        exp_q.push_back(ent(1,0,0,0,3'd0,8'h5A));
        drain("R7 after full");

        // R10 reset with a full silo and pending overrun
        for (int k = 0; k < 66; k++) begin
            @(negedge clk);
            line_vld = 8'h01; line_data = 64'(k);
        end
        @(negedge clk);
        line_vld = '0; line_data = '0;
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        check(rx_irq == 1'b0, "R10 emptied", 16'(rx_irq), 16'h0);
        check(rd_data == 16'h0000, "R10 read", rd_data, 16'h0000);
        check(silo_param == 16'h0000, "R10 param cleared", silo_param, 16'h0000);
        send(8'h40, 8'h00, 8'h00, 8'h00, 64'h77 << 48);
        exp_q.push_back(ent(0,0,0,0,3'd6,8'h77));
        drain("R10 overrun cleared");

        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule